// File: doc/BRIEF.md
# Operand Stack with Two Register Slots and Memory Spill

This block is the operand stack of a stack-oriented processor. The two topmost entries live in two data registers, called slot A and slot B, each with its own occupancy flag. Older entries sit in a memory region. A stack pointer `sp` always addresses the newest spilled word, and the value 0 means that nothing is spilled.

Words move between the registers and memory only when a register is really needed. A push spills to memory only when both slots are full. An operator that needs one or two operands pulls words back from memory only when the slots do not already hold enough of them. When an operator consumes entries and leaves slots empty, nothing is refilled until a later operator asks for operands.

The caller offers a command on a valid/ready handshake. While a command waits, `top_word` and `next_word` show its operands. For unary and binary operators the caller places the result on `cmd_data` in the cycle where ready is high. Arithmetic is done outside the block. Memory has one write or read port, and a read returns its data one cycle after the request.

Top module: `opstk_top`

## Requirements
- R1: After reset both slots are empty, `sp` is 0, no memory request is made, and a waiting push (code 0) is accepted at once.
- R2: A push (`cmd_op` = 0) completes in the cycle it is offered. Afterwards slot A holds `cmd_data`, `a_full` is 1 and `top_word` shows the pushed word.
- R3: If slot A is full when a push arrives, the old A word moves to slot B. A push makes no memory write unless both slots were full.
- R4: A push that finds both slots full writes the old B word to memory address `sp`+1 and increments `sp` by one, in the same cycle as the push.
- R5: A pushup reads memory at address `sp`. The returned word is loaded into a slot and `sp` is decremented by one.
- R6: Memory is read only while an operator is offered whose operands are not all in the slots. With no command offered, `mem_req` stays 0 and `sp` stays unchanged.
- R7: A binary operator (`cmd_op` = 3) is accepted only when A holds the top and B holds the second entry, shown on `top_word` and `next_word`. On acceptance the result goes into slot B and slot A becomes empty.
- R8: A pop (`cmd_op` = 1) removes the top entry, clearing A if A is full and otherwise clearing B. A unary operator (`cmd_op` = 2) replaces the top entry with `cmd_data` and leaves both flags unchanged.
- R9: An operator needing N operands while the slots hold H of them performs exactly N−H pushups when N>H, and none otherwise. With both slots empty, the first pushup fills A. With only B full, the B word moves to A before B is refilled.
- R10: Each pushup holds `cmd_ready` low for exactly two cycles: the read request and the data capture.
- R11: An operator that needs more entries than the slots and memory hold together is accepted in one cycle and changes neither the slots, the flags nor `sp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can complete this cycle |
| cmd_op | input | 2 | 0 push, 1 pop, 2 unary, 3 binary |
| cmd_data | input | W | Word to push, or operator result |
| top_word | output | W | Top entry (A if full, else B) |
| next_word | output | W | Slot B, the second operand of a binary operator |
| a_full | output | 1 | Slot A occupied |
| b_full | output | 1 | Slot B occupied |
| sp | output | AW | Address of the newest spilled word, 0 when none |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | W | Word being spilled |
| mem_rdata | input | W | Read data, one cycle after the request |

## Verification
Two things can fall in the same clock edge. A push into two full slots does the spill write, the A-to-B shift and the load of the new word all at once. A binary operator offered with only B full moves B into A in the same cycle that it issues the read for the new second entry. The bench provokes both with a long run of pseudo-random commands that keeps the depth swinging around the two-slot boundary. For every command it predicts the number of writes, reads and stall cycles, and the words on `top_word`/`next_word`, from its own model of the logical stack. After each command it compares the slot flags and `sp` with that model.

// File: rtl/opstk_pkg.sv
package opstk_pkg;

  typedef enum logic [1:0] {
    OP_PUSH   = 2'd0,
    OP_POP    = 2'd1,
    OP_UNARY  = 2'd2,
    OP_BINARY = 2'd3
  } stk_op_e;

  // operands an operation consumes from the stack
  function automatic logic [1:0] need_of(stk_op_e op);
    case (op)
      OP_POP, OP_UNARY: return 2'd1;
      OP_BINARY:        return 2'd2;
      default:          return 2'd0;
    endcase
  endfunction

  // entries held in the two register slots
  function automatic logic [1:0] held_of(logic af, logic bf);
    return {1'b0, af} + {1'b0, bf};
  endfunction

endpackage

// File: rtl/opstk_plan.sv
module opstk_plan
  import opstk_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic [1:0]    op,
  input  logic          a_occ,
  input  logic          b_occ,
  input  logic [AW-1:0] sp,
  output logic          enough,
  output logic          short_o,
  output logic          fill_b,
  output logic          lift
);
  localparam int TW = AW + 1;

  logic [1:0]    need;
  logic [1:0]    held;
  logic [TW-1:0] total;

  always_comb begin
    need    = need_of(stk_op_e'(op));
    held    = held_of(a_occ, b_occ);
    total   = TW'(held) + TW'(sp);
    enough  = held >= need;
    short_o = total < TW'(need);
    // refill target: B once A holds the top, else A
    fill_b  = a_occ | b_occ;
    lift    = !a_occ && b_occ;
  end
endmodule

// File: rtl/opstk_ptr.sv
module opstk_ptr #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [AW-1:0] sp
);
  always_ff @(posedge clk) begin
    if (!rst_n)   sp <= '0;
    else if (inc) sp <= sp + AW'(1);
    else if (dec) sp <= sp - AW'(1);
  end
endmodule

// File: rtl/opstk_top.sv
module opstk_top
  import opstk_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [W-1:0]  cmd_data,
  output logic [W-1:0]  top_word,
  output logic [W-1:0]  next_word,
  output logic          a_full,
  output logic          b_full,
  output logic [AW-1:0] sp,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic [W-1:0]  mem_rdata
);
  logic [W-1:0] reg_a, reg_b;
  logic         a_occ, b_occ;
  logic         filling, fill_to_b;
  logic         enough, short_c, fill_b, lift;
  stk_op_e      op;

  // named events
  logic idle, fire, push_fire, pop_fire, un_fire, bin_fire;
  logic spill, rd_issue, fill_done;

  assign op = stk_op_e'(cmd_op);

  opstk_plan #(.AW(AW)) u_plan (
    .op(cmd_op), .a_occ(a_occ), .b_occ(b_occ), .sp(sp),
    .enough(enough), .short_o(short_c), .fill_b(fill_b), .lift(lift)
  );

  opstk_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .inc(spill), .dec(fill_done), .sp(sp)
  );

  always_comb begin
    idle      = !filling;
    cmd_ready = idle && (op == OP_PUSH || enough || short_c);
    fire      = cmd_valid && cmd_ready;
    push_fire = fire && op == OP_PUSH;
    pop_fire  = fire && op == OP_POP    && !short_c;
    un_fire   = fire && op == OP_UNARY  && !short_c;
    bin_fire  = fire && op == OP_BINARY && !short_c;
    spill     = push_fire && a_occ && b_occ;
    rd_issue  = idle && cmd_valid && op != OP_PUSH && !enough && !short_c;
    fill_done = filling;
  end

  assign mem_req   = spill | rd_issue;
  assign mem_we    = spill;
  assign mem_addr  = spill ? sp + AW'(1) : sp;
  assign mem_wdata = reg_b;

  assign top_word  = a_occ ? reg_a : reg_b;
  assign next_word = reg_b;
  assign a_full    = a_occ;
  assign b_full    = b_occ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_a     <= '0;
      reg_b     <= '0;
      a_occ     <= 1'b0;
      b_occ     <= 1'b0;
      filling   <= 1'b0;
      fill_to_b <= 1'b0;
    end else if (fill_done) begin
      filling <= 1'b0;
      if (fill_to_b) begin
        reg_b <= mem_rdata;
        b_occ <= 1'b1;
      end else begin
        reg_a <= mem_rdata;
        a_occ <= 1'b1;
      end
    end else if (rd_issue) begin
      filling   <= 1'b1;
      fill_to_b <= fill_b;
      if (lift) begin
        reg_a <= reg_b;
        a_occ <= 1'b1;
        b_occ <= 1'b0;
      end
    end else if (push_fire) begin
      reg_a <= cmd_data;
      a_occ <= 1'b1;
      if (a_occ) begin
        reg_b <= reg_a;
        b_occ <= 1'b1;
      end
    end else if (pop_fire) begin
      if (a_occ) a_occ <= 1'b0;
      else       b_occ <= 1'b0;
    end else if (un_fire) begin
      if (a_occ) reg_a <= cmd_data;
      else       reg_b <= cmd_data;
    end else if (bin_fire) begin
      reg_b <= cmd_data;
      a_occ <= 1'b0;
    end
  end
endmodule

// File: rtl/opstk_chk.sv
module opstk_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] sp,
  input logic          a_full,
  input logic          b_full,
  input logic          push_fire,
  input logic          bin_fire,
  input logic          spill,
  input logic          rd_issue,
  input logic          fill_done
);
  logic [2:0] rd_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                     rd_cnt <= '0;
    else if (cmd_valid && cmd_ready) rd_cnt <= '0;
    else if (rd_issue)               rd_cnt <= rd_cnt + 3'd1;
  end

  a_r2_push_fills_a: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |=> a_full);

  a_r3_no_spill_with_room: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire && !(a_full && b_full)) |-> !mem_we);

  a_r4_spill_bumps_sp: assert property (@(posedge clk) disable iff (!rst_n)
    spill |=> sp == $past(sp) + AW'(1));

  a_r5_refill_drops_sp: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> sp == $past(sp) - AW'(1));

  a_r6_read_only_on_demand: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> cmd_valid);

  a_r7_binary_leaves_one: assert property (@(posedge clk) disable iff (!rst_n)
    bin_fire |=> (!a_full && b_full));

  a_r9_at_most_two_pushups: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt <= 3'd2);

  a_r10_stall_on_refill: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |=> !cmd_ready);
endmodule

bind opstk_top opstk_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .mem_req(mem_req), .mem_we(mem_we), .sp(sp), .a_full(a_occ), .b_full(b_occ),
  .push_fire(push_fire), .bin_fire(bin_fire), .spill(spill),
  .rd_issue(rd_issue), .fill_done(fill_done)
);

// File: tb/opstk_top_test.sv
module opstk_top_test;
  localparam int W  = 8;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_op = 2'd0;
  logic [W-1:0]  cmd_data = '0;
  logic [W-1:0]  top_word, next_word;
  logic          a_full, b_full;
  logic [AW-1:0] sp;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [W-1:0]  mem_wdata;
  logic [W-1:0]  mem_rdata = '0;
  logic [W-1:0]  ram [1<<AW];

  always #10 clk = ~clk;

  opstk_top #(.W(W), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .top_word(top_word),
    .next_word(next_word), .a_full(a_full), .b_full(b_full), .sp(sp),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else        mem_rdata <= ram[mem_addr];
    end
  end

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model of the logical stack
  logic [W-1:0] lst [64];
  int n = 0;
  bit maf = 0, mbf = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int op, input logic [W-1:0] d);
    int need, held, exp_reads, exp_writes, reads, writes, stalls;
    logic [W-1:0] dv;
    reads = 0; writes = 0; stalls = 0; dv = d;
    need = (op == 0) ? 0 : (op == 3) ? 2 : 1;
    held = int'(maf) + int'(mbf);
    exp_reads  = (n >= need && need > held) ? need - held : 0;
    exp_writes = (op == 0 && maf && mbf) ? 1 : 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_data = d;
    forever begin
      #1;
      if (mem_req && !mem_we) reads++;
      if (mem_req && mem_we) writes++;
      if (cmd_ready) break;
      stalls++;
      @(negedge clk);
    end
    if (op != 0 && n >= need) begin
      check("R7 R8 top operand", int'(top_word), int'(lst[n-1]));
      if (op == 3) begin
        check("R7 second operand", int'(next_word), int'(lst[n-2]));
        dv = lst[n-1] + lst[n-2];
        cmd_data = dv;
      end
    end
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    // model update
    case (op)
      0: begin lst[n] = dv; n++; if (maf) mbf = 1; maf = 1; end
      1: if (n >= 1) begin
           if (!maf && !mbf) maf = 1;
           if (maf) maf = 0; else mbf = 0;
           n--;
         end
      2: if (n >= 1) begin
           if (!maf && !mbf) maf = 1;
           lst[n-1] = dv;
         end
      default: if (n >= 2) begin
           maf = 0; mbf = 1; lst[n-2] = dv; n--;
         end
    endcase
    check("R5 R9 pushup count", reads, exp_reads);
    check("R10 stall cycles", stalls, 2 * exp_reads);
    check("R3 R4 spill writes", writes, exp_writes);
    check("R2 R3 R7 R8 R11 a_full", int'(a_full), int'(maf));
    check("R3 R7 R8 R11 b_full", int'(b_full), int'(mbf));
    check("R4 R5 R11 sp", int'(sp), n - int'(maf) - int'(mbf));
    if (maf || mbf) check("R2 R5 R8 top_word", int'(top_word), int'(lst[n-1]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    int op;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 a_full", int'(a_full), 0);
    check("R1 b_full", int'(b_full), 0);
    check("R1 sp", int'(sp), 0);
    check("R1 mem_req", int'(mem_req), 0);
    check("R1 push ready", int'(cmd_ready), 1);

    // R11 underflow on empty and on a single entry
    run(1, 8'h00);
    run(3, 8'h00);
    run(2, 8'h11);
    run(0, 8'h05);
    run(3, 8'h00);

    // worked expression: push, push, binary, push, binary
    run(0, 8'h03); run(0, 8'h04); run(3, 8'h00); run(0, 8'h07); run(3, 8'h00);

    // R4 spills, then R6 laziness after draining the slots
    for (int i = 0; i < 6; i++) run(0, 8'(8'h20 + i));
    run(1, 8'h00); run(1, 8'h00);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #1;
      check("R6 no idle read", int'(mem_req), 0);
      check("R6 sp steady", int'(sp), n);
    end
    // R9 two pushups with both slots empty, then lift case
    run(3, 8'h00);
    run(3, 8'h00);
    run(2, 8'h99);
    run(1, 8'h00);

    // R2 R3 R4 R5 R7 R8 R9 R10 mixed sweep around the slot boundary
    lf = 16'hACE1;
    for (int k = 0; k < 600; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      op = int'(lf[1:0]);
      if (op == 0 && n >= 13) op = 3;
      if (op != 0 && n == 0 && lf[5]) op = 0;
      run(op, lf[11:4]);
    end
    while (n > 0) run(1, 8'h00);
    run(1, 8'h00);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule